// File: doc/BRIEF.md
# Conversion-Control Sequencer for a Successive-Approximation Converter

This block is the digital controller of a successive-approximation converter. Three control lines start a conversion: an active-high enable, an active-low select and a read/convert line that requests a conversion when low. Each line passes through its own two-flop synchronizer. The start event is the moment their combination first becomes true, so the line that settles last is the one that starts the conversion.

At that start the block samples a length-select line. It then runs an 8-bit or a 12-bit conversion, most significant bit first, at one bit decision per clock. The trial word goes out to an external DAC, and an external comparator answers whether the analog input is at or above it. A busy flag covers the whole conversion.

The result word drives a three-state data bus through an enable signal. That enable is active only while the converter is idle, selected and held in read. In stand-alone use the enable is tied high and the select is tied low, and a single read/convert line does the rest. A falling edge on that line starts a conversion, and the line being high makes the result readable.

Top module: `adc_ctrl_seq`

## Requirements
- R1: A start occurs when `chip_en`=1, `chip_sel_n`=0 and `rd_conv`=0 first hold together while `busy` is low. `busy` rises exactly 3 clock edges after the last of these inputs changes, whichever input it is, including when all three change at once.
- R2: `busy` stays high for exactly 12 clock cycles for a full conversion and exactly 8 cycles for a short one.
- R3: `len_sel` is sampled only at the start: 1 selects the short 8-bit conversion and 0 selects the full 12-bit conversion. Changes on `len_sel` during a conversion have no effect.
- R4: Bit decisions run from bit 11 downward. Each decision sets the trial bit on `trial` and keeps it when `cmp_hi`=1, so a full conversion returns the largest code that is not above the analog level.
- R5: After a short conversion, `dout[11:4]` holds the eight decided bits and `dout[3:0]` reads 4'b1000.
- R6: `dout_en` is the registered value of (`chip_en`=1, `chip_sel_n`=0, `rd_conv`=1, `busy`=0). It is low on the cycle after a start and stays low until the conversion has finished.
- R7: A new start condition that appears while `busy` is high is ignored. A condition that is still true when `busy` falls does not begin another conversion without a fresh edge.
- R8: Synchronous reset clears `busy`, `dout` and `trial`. After reset with read asserted, the bus is enabled and shows zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Enable, active high, asynchronous |
| chip_sel_n | input | 1 | Select, active low, asynchronous |
| rd_conv | input | 1 | High requests a read, low requests a conversion |
| len_sel | input | 1 | 1 = 8-bit conversion, 0 = 12-bit, sampled at start |
| cmp_hi | input | 1 | Comparator: analog level is at or above `trial` |
| busy | output | 1 | High during a conversion |
| dout_en | output | 1 | Enable for the three-state data bus |
| dout | output | 12 | Result word |
| trial | output | 12 | Trial word to the DAC |

## Verification
The assertions take `cmp_hi` to be a settled response to the current `trial` value within the same cycle. They also take the control lines to change no faster than the synchronizers can resolve, so the start condition is seen as a clean edge. The bench meets both assumptions. Its comparator is a combinational compare of a held input code against `trial`. It changes control lines only at falling clock edges and holds each level for at least one full cycle, including the short select pulse it uses to re-raise the start condition mid-conversion.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic {
    LEN_FULL  = 1'b0,
    LEN_SHORT = 1'b1
  } conv_len_e;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= INIT;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= INIT;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/start_detect.sv
module start_detect (
  input  logic clk,
  input  logic rst,
  input  logic en_s,
  input  logic sel_n_s,
  input  logic rdc_s,
  input  logic busy,
  output logic start
);
  logic cond, cond_q;

  // all three qualifiers meet in one cycle: whichever arrives last fires it
  assign cond  = en_s & ~sel_n_s & ~rdc_s;
  assign start = cond & ~cond_q & ~busy;

  always_ff @(posedge clk) begin
    if (rst) cond_q <= 1'b0;
    else     cond_q <= cond;
  end

  // R1: a start is a single-cycle event
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import conv_seq_pkg::*;
#(
  parameter int W = 12,
  parameter int S = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         len_sel,
  input  logic         cmp_hi,
  output logic         busy,
  output logic [W-1:0] code
);
  localparam int IW = $clog2(W);
  localparam logic [IW-1:0] TOP        = IW'(W - 1);
  localparam logic [IW-1:0] LAST_SHORT = IW'(W - S);
  localparam logic [W-1:0]  LOWMASK    = W'((1 << (W - S)) - 1);
  localparam logic [W-1:0]  PAT        = W'(1 << (W - S - 1));

  conv_len_e    len_q;
  logic [IW-1:0] idx_q;
  logic [W-1:0]  sar_q, sar_n;
  logic          busy_q;
  logic          last;

  assign last = (idx_q == ((len_q == LEN_SHORT) ? LAST_SHORT : '0));

  always_comb begin
    sar_n = sar_q;
    sar_n[idx_q] = cmp_hi;
    if (last) begin
      if (len_q == LEN_SHORT) sar_n = (sar_n & ~LOWMASK) | PAT;
    end else begin
      sar_n[idx_q - IW'(1)] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      len_q  <= LEN_FULL;
      idx_q  <= '0;
      sar_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      len_q  <= conv_len_e'(len_sel);
      idx_q  <= TOP;
      sar_q  <= W'(1) << (W - 1);
    end else if (busy_q) begin
      sar_q <= sar_n;
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q - IW'(1);
    end
  end

  assign busy = busy_q;
  assign code = sar_q;

  // R3: the latched length holds for the whole conversion
  a_r3_len_held: assert property (@(posedge clk) disable iff (rst)
    busy_q && $past(busy_q) |-> $stable(len_q));
  // R2: the decision index stays inside the selected length
  a_r2_idx_range: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (idx_q <= TOP) &&
               (idx_q >= ((len_q == LEN_SHORT) ? LAST_SHORT : '0)));
  // R7: no restart from the MSB while a conversion runs
  a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
    busy_q && $past(busy_q) |-> idx_q != TOP);
  // R5: a short conversion ends with the fixed low pattern
  a_r5_short_tail: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) && (len_q == LEN_SHORT) |-> (sar_q & LOWMASK) == PAT);
endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq #(
  parameter int W = 12,
  parameter int S = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         chip_en,
  input  logic         chip_sel_n,
  input  logic         rd_conv,
  input  logic         len_sel,
  input  logic         cmp_hi,
  output logic         busy,
  output logic         dout_en,
  output logic [W-1:0] dout,
  output logic [W-1:0] trial
);
  logic [3:0] ctl_s;
  logic       start;
  logic       busy_i;
  logic [W-1:0] code;
  logic       oe_q;

  // bit order: 3 enable, 2 select_n, 1 read/convert, 0 length
  ctl_sync #(.N(4), .STAGES(SYNC), .INIT(4'b0100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({chip_en, chip_sel_n, rd_conv, len_sel}),
    .q   (ctl_s)
  );

  start_detect u_start (
    .clk     (clk),
    .rst     (rst),
    .en_s    (ctl_s[3]),
    .sel_n_s (ctl_s[2]),
    .rdc_s   (ctl_s[1]),
    .busy    (busy_i),
    .start   (start)
  );

  sar_engine #(.W(W), .S(S)) u_sar (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .len_sel (ctl_s[0]),
    .cmp_hi  (cmp_hi),
    .busy    (busy_i),
    .code    (code)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= ctl_s[3] & ~ctl_s[2] & ctl_s[1] & ~busy_i;
  end

  assign busy    = busy_i;
  assign dout_en = oe_q;
  assign dout    = code;
  assign trial   = code;

  // R6: bus released on the cycle after a start
  a_r6_hiz_on_start: assert property (@(posedge clk) disable iff (rst)
    start |=> !oe_q);
  // R6: bus stays released while conversion continues
  a_r6_off_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy_i && $past(busy_i) |-> !oe_q);
endmodule

// File: tb/sim_adc_ctrl_seq.sv
module sim_adc_ctrl_seq;
  localparam int CLK_P = 10;
  localparam int W = 12;
  localparam int S = 8;

  logic clk = 1'b0;
  logic rst, chip_en, chip_sel_n, rd_conv, len_sel;
  logic cmp_hi, busy, dout_en;
  logic [W-1:0] dout, trial, vin;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  assign cmp_hi = (vin >= trial);

  adc_ctrl_seq #(.W(W), .S(S), .SYNC(2)) u0 (
    .clk(clk), .rst(rst), .chip_en(chip_en), .chip_sel_n(chip_sel_n),
    .rd_conv(rd_conv), .len_sel(len_sel), .cmp_hi(cmp_hi),
    .busy(busy), .dout_en(dout_en), .dout(dout), .trial(trial)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_code(input int v, input bit short_v);
    if (short_v) return ((v >> (W - S)) << (W - S)) | (1 << (W - S - 1));
    return v;
  endfunction

  task automatic convert(input int v, input bit short_v, input int mode);
    int lat, w;
    bit hiz_ok, quiet;
    vin = W'(v);
    case (mode)
      0: begin chip_en = 1; chip_sel_n = 0; rd_conv = 1; end
      1: begin chip_en = 1; chip_sel_n = 1; rd_conv = 0; end
      2: begin chip_en = 0; chip_sel_n = 0; rd_conv = 0; end
      default: begin chip_en = 0; chip_sel_n = 1; rd_conv = 1; end
    endcase
    len_sel = short_v;
    repeat (4) @(negedge clk);
    if (mode == 1 || mode == 2) check(dout_en == 0, "R6 idle not selected", dout_en, 0);
    case (mode)
      0: rd_conv = 0;
      1: chip_sel_n = 0;
      2: chip_en = 1;
      default: begin chip_en = 1; chip_sel_n = 0; rd_conv = 0; end
    endcase
    lat = 0;
    do begin @(negedge clk); lat++; end while (!busy && lat < 10);
    check(lat == 3, "R1 start latency", lat, 3);
    w = 0;
    hiz_ok = 1;
    while (busy && w < 40) begin
      if (dout_en) hiz_ok = 0;
      w++;
      if (w == 1) begin
        len_sel = ~short_v;        // R3: ignored mid-conversion
        if (mode == 0) rd_conv = 1;
        if (mode == 2) chip_sel_n = 1;
      end
      if (w == 2 && mode == 2) chip_sel_n = 0;  // R7: re-raised start ignored
      @(negedge clk);
    end
    check(w == (short_v ? S : W), "R2/R3 busy length", w, short_v ? S : W);
    check(hiz_ok, "R6 bus off during conversion", hiz_ok, 1);
    quiet = 1;
    repeat (6) begin @(negedge clk); if (busy) quiet = 0; end
    check(quiet, "R7 no restart without new edge", quiet, 1);
    rd_conv = 1;
    repeat (4) @(negedge clk);
    check(dout_en == 1, "R6 bus on after read", dout_en, 1);
    check(int'(dout) == expect_code(v, short_v),
          short_v ? "R5 short result" : "R4 full result",
          dout, expect_code(v, short_v));
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int k;
    rst = 1; chip_en = 1; chip_sel_n = 0; rd_conv = 1; len_sel = 0; vin = '0;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    check(busy == 0, "R8 reset busy", busy, 0);
    check(dout == 0, "R8 reset data", dout, 0);
    check(dout_en == 1, "R8 bus on after reset", dout_en, 1);
    k = 0;
    for (int v = 0; v < (1 << W); v += 37) begin
      convert(v, k[2], k % 4);
      k++;
    end
    convert((1 << W) - 1, 1'b0, 3);
    convert((1 << W) - 1, 1'b1, 0);
    convert(0, 1'b1, 1);
    convert(15, 1'b1, 2);
    convert(16, 1'b1, 3);
    convert(2048, 1'b0, 1);
    convert(2047, 1'b0, 2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule